// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a single-clock burst memory with a registered address path and a registered read output. It contains a small byte-laned array. An access is opened by one of two address strobes. The processor-side strobe is qualified by the primary chip select and always starts a read. The controller-side strobe loads an address whether or not the primary select is active, and it can write on the same edge. After an access is opened, a 2-bit counter on the two lowest address bits produces the next addresses of a four-word burst, in linear or interleaved order. An active-low step input moves the burst forward, and holding that input high repeats the current word.

Writes are byte-masked and take effect at the clock edge where they are issued. Read data leaves through a two-register pipeline, so the first word of a burst reaches the bus one edge after the addressing edge and each following word arrives one edge later. The bidirectional data bus is modelled as separate input, output and drive-enable signals. The drive enable is forced low without waiting for a clock when output enable is inactive, when sleep is active, and during a programmable wake-up window after sleep ends.

Top module: `sync_burst_sram`

## Requirements
- R1: After reset, `dq_oe_o` is low, and no access takes place until a strobe opens one.
- R2: An access is opened only on a rising edge where a strobe is active, and the address and selects are captured on that edge. The access is selected only when `cs_ni`=0, `cs_hi_i`=1 and `cs_lo_ni`=0. If both strobes are active while `cs_ni`=0, the processor-side strobe takes priority.
- R3: A read accessed at edge E appears on `dq_o` with `dq_oe_o`=1 after edge E+1. The burst words follow at one word per edge.
- R4: `proc_strobe_ni` has no effect while `cs_ni`=1. An open burst continues from its current address.
- R5: Burst word k (k=0,1,2,...) keeps address bits [ADDR_W-1:2] from the load. With `interleave_i`=0, its low two bits are (start+k) mod 4. With `interleave_i`=1, they are start XOR (k mod 4). After four steps the burst wraps back to the start word.
- R6: On a non-load edge with `burst_step_ni`=1, the address does not change, and the same word is accessed again.
- R7: A strobe during an open burst loads a new base address, and the next burst word is taken from that new base.
- R8: `global_wr_ni`=0 writes all four byte lanes. Otherwise, `byte_wr_en_ni`=0 writes each lane b whose `byte_we_ni[b]`=0 (lane b is `dq_i[8b+7:8b]`). If both `global_wr_ni` and `byte_wr_en_ni` are 1, nothing is written and the cycle is a read.
- R9: An edge that loads through the processor-side strobe is always a read. Write controls on the edges that follow write the current burst address. An edge that loads through the controller-side strobe writes `dq_i` to `addr_i` on that same edge.
- R10: `oe_ni`=1 forces `dq_oe_o` low without waiting for a clock edge.
- R11: A load with any select inactive closes the burst. `dq_oe_o` falls after the edge that follows the deselecting edge. Write controls have no effect until the next strobe.
- R12: `sleep_i`=1 forces `dq_oe_o` low at once, blocks loads and writes, and drops the open burst. These effects last until WAKE_CYCLES edges have passed after `sleep_i` falls. Array contents are kept through sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address, captured on load edges |
| proc_strobe_ni | input | 1 | Processor-side address strobe, active low, gated by `cs_ni` |
| ctrl_strobe_ni | input | 1 | Controller-side address strobe, active low |
| burst_step_ni | input | 1 | Advances the burst when low, holds the address when high |
| cs_ni | input | 1 | Primary chip select, active low |
| cs_hi_i | input | 1 | Active-high chip select |
| cs_lo_ni | input | 1 | Second active-low chip select |
| global_wr_ni | input | 1 | Writes all lanes when low |
| byte_wr_en_ni | input | 1 | Qualifies the per-lane enables, active low |
| byte_we_ni | input | BYTES | Per-lane write enables, active low |
| interleave_i | input | 1 | 0 selects linear burst order, 1 selects interleaved order |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous sleep request |
| dq_i | input | 8*BYTES | Write data from the bus |
| dq_o | output | 8*BYTES | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The assertions assume three things about the inputs: the burst mode input is held steady for the whole of a burst, no bus reads are requested during sleep or the wake-up window, and the device is deselected before sleep is entered. The bench drives every input on the falling clock edge and changes `interleave_i` only between bursts. It enters sleep only after a read has ended and a deselect has been issued. After sleep ends, it keeps a read request pending so that the blocked edges can be seen directly at the ports.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic {
    BURST_LINEAR      = 1'b0,
    BURST_INTERLEAVED = 1'b1
  } burst_mode_e;

  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step,
                                              input burst_mode_e mode);
    return (mode == BURST_INTERLEAVED) ? (start ^ step) : (start + step);
  endfunction
endpackage

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              block_i,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              cs_ni,
  input  logic              cs_hi_i,
  input  logic              cs_lo_ni,
  input  logic              burst_step_ni,
  input  logic              interleave_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              acc_valid_o,
  output logic              acc_wr_ok_o,
  output logic [ADDR_W-1:0] acc_addr_o
);
  localparam int HI_W = ADDR_W - 2;

  logic            sel_q;
  logic [HI_W-1:0] base_q;
  logic [1:0]      start_q;
  logic [1:0]      cnt_q;

  logic       load_proc, load_ctrl, load, ce_ok;
  logic [1:0] cnt_nxt;

  always_comb begin
    load_proc   = !proc_strobe_ni && !cs_ni && !block_i;
    load_ctrl   = !ctrl_strobe_ni && !block_i;
    load        = load_proc || load_ctrl;
    ce_ok       = !cs_ni && cs_hi_i && !cs_lo_ni;
    cnt_nxt     = burst_step_ni ? cnt_q : cnt_q + 2'd1;
    acc_valid_o = load ? ce_ok : (sel_q && !block_i);
    acc_wr_ok_o = !load_proc;
    acc_addr_o  = load ? addr_i
                       : {base_q, burst_offset(start_q, cnt_nxt, burst_mode_e'(interleave_i))};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= 1'b0;
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (block_i) begin
      sel_q <= 1'b0;
    end else if (load) begin
      sel_q   <= ce_ok;
      base_q  <= addr_i[ADDR_W-1:2];
      start_q <= addr_i[1:0];
      cnt_q   <= '0;
    end else if (sel_q && !burst_step_ni) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  // R4
  proc_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && cs_ni && ctrl_strobe_ni) |=> ($stable(base_q) && $stable(start_q)));

  // R6
  suspend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load && burst_step_ni) |=> $stable(cnt_q));

  // R11
  deselect_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !ce_ok) |=> !sel_q);
endmodule

// File: rtl/sbs_wr_mask.sv
module sbs_wr_mask #(
  parameter int BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             global_wr_ni,
  input  logic             byte_wr_en_ni,
  input  logic [BYTES-1:0] byte_we_ni,
  output logic [BYTES-1:0] mask_o
);
  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign mask_o[b] = !global_wr_ni || (!byte_wr_en_ni && !byte_we_ni[b]);
  end

  // R8
  no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (global_wr_ni && byte_wr_en_ni) |-> (mask_o == '0));
endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int ADDR_W = 6,
  parameter int BYTES  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_valid_i,
  input  logic               acc_we_i,
  input  logic [BYTES-1:0]   acc_mask_i,
  input  logic [ADDR_W-1:0]  acc_addr_i,
  input  logic [8*BYTES-1:0] wdata_i,
  output logic [8*BYTES-1:0] rd_data_o,
  output logic               rd_valid_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic              acc_rd_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic              rd_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_rd_q   <= 1'b0;
      rd_addr_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      acc_rd_q   <= acc_valid_i && !acc_we_i;
      rd_addr_q  <= acc_addr_i;
      rd_valid_q <= acc_rd_q;
    end
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [7:0] lane_mem [DEPTH];
    logic [7:0] lane_q;

    always_ff @(posedge clk_i) begin
      if (acc_we_i && acc_mask_i[b]) lane_mem[acc_addr_i] <= wdata_i[8*b +: 8];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       lane_q <= '0;
      else if (acc_rd_q) lane_q <= lane_mem[rd_addr_q];
    end

    assign rd_data_o[8*b +: 8] = lane_q;
  end

  assign rd_valid_o = rd_valid_q;

  // R3
  pipe_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_rd_q |=> rd_valid_q);

  // R11
  pipe_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_rd_q |=> !rd_valid_q);
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int ADDR_W      = 6,
  parameter int BYTES       = 4,
  parameter int WAKE_CYCLES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               proc_strobe_ni,
  input  logic               ctrl_strobe_ni,
  input  logic               burst_step_ni,
  input  logic               cs_ni,
  input  logic               cs_hi_i,
  input  logic               cs_lo_ni,
  input  logic               global_wr_ni,
  input  logic               byte_wr_en_ni,
  input  logic [BYTES-1:0]   byte_we_ni,
  input  logic               interleave_i,
  input  logic               oe_ni,
  input  logic               sleep_i,
  input  logic [8*BYTES-1:0] dq_i,
  output logic [8*BYTES-1:0] dq_o,
  output logic               dq_oe_o
);
  localparam int WAKE_W = $clog2(WAKE_CYCLES + 1);

  logic [WAKE_W-1:0] wake_q;
  logic              blocked;
  logic              acc_valid, acc_wr_ok, acc_we, rd_valid;
  logic [ADDR_W-1:0] acc_addr;
  logic [BYTES-1:0]  mask;

  assign blocked = sleep_i || (wake_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             wake_q <= '0;
    else if (sleep_i)        wake_q <= WAKE_W'(WAKE_CYCLES);
    else if (wake_q != '0)   wake_q <= wake_q - WAKE_W'(1);
  end

  sbs_burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .block_i        (blocked),
    .proc_strobe_ni (proc_strobe_ni),
    .ctrl_strobe_ni (ctrl_strobe_ni),
    .cs_ni          (cs_ni),
    .cs_hi_i        (cs_hi_i),
    .cs_lo_ni       (cs_lo_ni),
    .burst_step_ni  (burst_step_ni),
    .interleave_i   (interleave_i),
    .addr_i         (addr_i),
    .acc_valid_o    (acc_valid),
    .acc_wr_ok_o    (acc_wr_ok),
    .acc_addr_o     (acc_addr)
  );

  sbs_wr_mask #(.BYTES(BYTES)) u_mask (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .global_wr_ni  (global_wr_ni),
    .byte_wr_en_ni (byte_wr_en_ni),
    .byte_we_ni    (byte_we_ni),
    .mask_o        (mask)
  );

  assign acc_we = acc_valid && acc_wr_ok && (|mask);

  sbs_store #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid),
    .acc_we_i    (acc_we),
    .acc_mask_i  (mask),
    .acc_addr_i  (acc_addr),
    .wdata_i     (dq_i),
    .rd_data_o   (dq_o),
    .rd_valid_o  (rd_valid)
  );

  assign dq_oe_o = rd_valid && !oe_ni && !blocked;

  // R10
  oe_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_oe_o);

  // R12
  sleep_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !dq_oe_o);

  // R12
  wake_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_q != '0) |-> (!dq_oe_o && !acc_valid));

  // R9
  proc_load_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_ni && !cs_ni && !blocked) |-> !acc_we);
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 6;
  localparam int NB    = 4;
  localparam int DW    = 8 * NB;
  localparam int WAKE  = 2;
  localparam int WD    = 200000;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          proc_n, ctrl_n, step_n, cs_n, cs_hi, cs_lo_n;
  logic          gw_n, bwe_n, il, oe_n, sleep;
  logic [NB-1:0] bw_n;
  logic [DW-1:0] dq_in, dq_out;
  logic          dq_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [DW-1:0] model [1 << AW];

  always #(CLK_P / 2) clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .BYTES(NB), .WAKE_CYCLES(WAKE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .proc_strobe_ni(proc_n), .ctrl_strobe_ni(ctrl_n), .burst_step_ni(step_n),
    .cs_ni(cs_n), .cs_hi_i(cs_hi), .cs_lo_ni(cs_lo_n),
    .global_wr_ni(gw_n), .byte_wr_en_ni(bwe_n), .byte_we_ni(bw_n),
    .interleave_i(il), .oe_ni(oe_n), .sleep_i(sleep),
    .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  function automatic logic [AW-1:0] baddr(input logic [AW-1:0] a, input int k, input bit mode);
    logic [1:0] s  = a[1:0];
    logic [1:0] kk = 2'(k);
    return {a[AW-1:2], mode ? (s ^ kk) : (s + kk)};
  endfunction

  function automatic logic [DW-1:0] fill(input int a);
    return {8'(a), 8'(~a), 8'(a + 3), 8'(a ^ 8'h5c)};
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle();
    addr = '0; proc_n = 1; ctrl_n = 1; step_n = 1; cs_n = 0; cs_hi = 1; cs_lo_n = 0;
    gw_n = 1; bwe_n = 1; bw_n = '1; il = 0; oe_n = 0; sleep = 0; dq_in = '0;
  endtask

  task automatic deselect();
    ctrl_n = 0; cs_n = 1; step();
    ctrl_n = 1; cs_n = 0;
  endtask

  task automatic wr_lanes(input int a, input bit g, input bit be, input logic [NB-1:0] bw,
                          input logic [DW-1:0] d);
    ctrl_n = 0; addr = AW'(a); gw_n = g; bwe_n = be; bw_n = bw; dq_in = d;
    step();
    ctrl_n = 1; gw_n = 1; bwe_n = 1; bw_n = '1;
    for (int b = 0; b < NB; b++)
      if (!g || (!be && !bw[b])) model[a][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic single_read(input int a, input string req);
    proc_n = 0; addr = AW'(a); step();
    proc_n = 1; step_n = 1; step();
    chk(req, DW'(dq_oe), DW'(1));
    chk(req, dq_out, model[a]);
    deselect();
  endtask

  task automatic burst_chk(input int a, input bit mode);
    il = mode; proc_n = 0; addr = AW'(a); step();
    proc_n = 1; step_n = 0;
    for (int k = 0; k < 5; k++) begin
      step();
      if (k == 0) chk("R3", DW'(dq_oe), DW'(1));
      chk("R5", dq_out, model[baddr(AW'(a), k, mode)]);
    end
    step_n = 1; deselect(); il = 0;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    // R1: reset state
    chk("R1", DW'(dq_oe), DW'(0));

    // R9 / R7: back-to-back controller-strobe writes fill the array
    for (int a = 0; a < (1 << AW); a++) wr_lanes(a, 0, 1, '1, fill(a));
    deselect();
    chk("R1", DW'(dq_oe), DW'(0));

    // R5 / R3 / R2: every base and start offset in both orders
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << AW); a++) burst_chk(a, bit'(m));

    // R6: suspend repeats the word
    proc_n = 0; addr = AW'(9); step();
    proc_n = 1; step_n = 1; step();
    chk("R6", dq_out, model[9]);
    step();
    chk("R6", dq_out, model[9]);
    step_n = 0; step();
    chk("R6", dq_out, model[9]);
    step();
    chk("R6", dq_out, model[10]);
    step_n = 1; deselect();

    // R4: gated processor strobe leaves the burst running
    proc_n = 0; addr = AW'(16); step();
    proc_n = 1; step_n = 0; step();
    chk("R4", dq_out, model[16]);
    proc_n = 0; cs_n = 1; addr = AW'(40); step();
    chk("R4", dq_out, model[17]);
    proc_n = 1; cs_n = 0; step();
    chk("R4", dq_out, model[18]);
    step_n = 1; deselect();

    // R7: controller strobe mid-burst restarts at new base
    proc_n = 0; addr = AW'(20); step();
    proc_n = 1; step_n = 0; step();
    chk("R7", dq_out, model[20]);
    ctrl_n = 0; addr = AW'(33); step();
    chk("R7", dq_out, model[21]);
    ctrl_n = 1; step();
    chk("R7", dq_out, model[33]);
    step();
    chk("R7", dq_out, model[34]);
    step_n = 1; deselect();

    // R2 / R9: both strobes, processor wins, write controls ignored
    proc_n = 0; ctrl_n = 0; addr = AW'(7); gw_n = 0; dq_in = 32'hDEADBEEF; step();
    proc_n = 1; ctrl_n = 1; gw_n = 1; step_n = 1; step();
    chk("R2", dq_out, model[7]);
    deselect();

    // R9: processor-strobe write on following edges
    proc_n = 0; addr = AW'(44); step();
    proc_n = 1; step_n = 1; bwe_n = 0; bw_n = 4'b1010; dq_in = 32'h11223344; step();
    model[44][7:0] = 8'h44; model[44][23:16] = 8'h22;
    step_n = 0; gw_n = 0; bwe_n = 1; bw_n = '1; dq_in = 32'hCAFEF00D; step();
    model[45] = 32'hCAFEF00D;
    gw_n = 1; step_n = 1; deselect();
    single_read(44, "R9");
    single_read(45, "R9");

    // R8: all lane patterns, global override, unqualified lanes
    for (int p = 0; p < 16; p++) begin
      wr_lanes(50, 1, 0, 4'(p), fill(p + 100));
      deselect();
      single_read(50, "R8");
    end
    wr_lanes(51, 0, 1, 4'b1111, 32'h0BADC0DE);
    deselect();
    single_read(51, "R8");
    wr_lanes(52, 1, 1, 4'b0000, 32'hFFFF0000);
    deselect();
    single_read(52, "R8");

    // R10: asynchronous output enable
    proc_n = 0; addr = AW'(12); step();
    proc_n = 1; step_n = 1; step();
    chk("R10", DW'(dq_oe), DW'(1));
    oe_n = 1; #1;
    chk("R10", DW'(dq_oe), DW'(0));
    oe_n = 0; #1;
    chk("R10", DW'(dq_oe), DW'(1));
    deselect();

    // R11: single-cycle deselect, later writes ignored
    proc_n = 0; addr = AW'(24); step();
    proc_n = 1; step_n = 0; step();
    ctrl_n = 0; cs_n = 1; step();
    chk("R11", DW'(dq_oe), DW'(1));
    ctrl_n = 1; cs_n = 0; step();
    chk("R11", DW'(dq_oe), DW'(0));
    gw_n = 0; dq_in = 32'h55AA55AA; step();
    gw_n = 1; step_n = 1;
    single_read(26, "R11");
    single_read(27, "R11");

    // R12: sleep blocks output and writes, wake window
    proc_n = 0; addr = AW'(10); step();
    proc_n = 1; step_n = 1; step();
    deselect();
    sleep = 1; #1;
    chk("R12", DW'(dq_oe), DW'(0));
    ctrl_n = 0; addr = AW'(3); gw_n = 0; dq_in = 32'h12345678; step(); step();
    ctrl_n = 1; gw_n = 1;
    sleep = 0;
    proc_n = 0; addr = AW'(3); step();
    chk("R12", DW'(dq_oe), DW'(0));
    step();
    chk("R12", DW'(dq_oe), DW'(0));
    step();
    proc_n = 1; step();
    chk("R12", DW'(dq_oe), DW'(1));
    chk("R12", dq_out, model[3]);
    deselect();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule